// File: doc/BRIEF.md
# Reset Source Sequencing Controller

This block collects reset requests from four sources (a power-on event, an external active-low reset pin, a software request and a watchdog request). It sets how long the processor core stays in reset. The length depends on the source and on the state of the main oscillator when the request arrives. A request that finds the oscillator stopped or still warming up gets the full oscillation stabilization wait. A software or watchdog request that arrives while the main clock is running gets a short fixed pulse of four instruction cycles. An external request that arrives while the main clock is running holds the core only for as long as the pin stays low. Whatever the source, the core leaves reset into normal main-clock operation. The clock controller reads the released core reset as the point where execution restarts on the main clock.

Two static strap inputs shape the behaviour. The power-on option enables the stabilization wait for power-on and external requests; without it, those requests have no wait. The reset-output option lets the block pull the shared reset pin low during every timed wait. A cause register keeps the source of the latest reset event. A core reset does not clear it; only the block's own reset does.

Top module: `rst_seq_ctrl`

## Requirements
- R1: After `rst_n` has been released and no request is pending, `core_rst_n` is 1, `pin_drive_low` is 0 and `cause` is 4'b0000.
- R2: A `sw_req` or `wdt_req` pulse sampled while `osc_state` is 2'b00 (main clock running) holds `core_rst_n` low for exactly INSTR_TICKS*PULSE_INSTR cycles (16 by default), starting the cycle after the request.
- R3: A `sw_req` or `wdt_req` sampled while `osc_state` is not 2'b00 (2'b01 stopped, 2'b10 warming, 2'b11 treated as not running) holds `core_rst_n` low for exactly STAB_TICKS cycles, whatever `opt_por` is.
- R4: `ext_rst_n` passes through a two-flop synchronizer. With the main clock running, `core_rst_n` goes low two clock edges after the pin is sampled low and goes high two edges after the pin is sampled high, with no added wait.
- R5: With `opt_por`=1, a falling `ext_rst_n` that the synchronizer detects while `osc_state` is not 2'b00 starts the stabilization wait on the following edge. The core is released only when that wait has ended and the synchronized pin is high, whichever comes later.
- R6: With `opt_por`=1, every cycle in which `por_req` is sampled high reloads the full stabilization wait. `core_rst_n` rises STAB_TICKS cycles after the last such cycle.
- R7: With `opt_por`=0, neither `por_req` nor `ext_rst_n` starts a stabilization wait. `core_rst_n` is low for each cycle that `por_req` was high on the previous edge, and while the synchronized pin is low.
- R8: `pin_drive_low` is 1 exactly while a stabilization wait or an instruction-cycle pulse is running and `opt_rst_out` is 1. It is 0 at all other times, and always 0 when `opt_rst_out` is 0.
- R9: On any edge that has at least one event, `cause` is overwritten with the set of events of that edge. The bits are: bit0 = `por_req` rising, bit1 = synchronized external pin falling, bit2 = `sw_req`, bit3 = `wdt_req`. Simultaneous events set several bits. Core resets do not clear `cause`; only `rst_n` does.
- R10: A request that arrives during a running wait or pulse reloads that timer to its full length, so a running reset is never shortened.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock that keeps counting during stabilization |
| rst_n | input | 1 | Synchronous active-low reset of the controller itself |
| por_req | input | 1 | Power-on event, active high, already synchronous |
| ext_rst_n | input | 1 | External reset pin level, active low, asynchronous |
| sw_req | input | 1 | Software reset request, one-cycle pulse |
| wdt_req | input | 1 | Watchdog reset request, one-cycle pulse |
| osc_state | input | 2 | Main oscillator: 00 running, 01 stopped, 10 warming, 11 not running |
| opt_por | input | 1 | Static option: power-on/external requests use the stabilization wait |
| opt_rst_out | input | 1 | Static option: drive the reset pin low during timed waits |
| core_rst_n | output | 1 | Core reset, active low |
| pin_drive_low | output | 1 | Open-drain pull-down enable for the reset pin |
| cause | output | 4 | Source set of the latest reset event |

## Verification
A corrupted timer shows up as a core release that comes too early or too late. The per-cycle comparison catches it on the first cycle where `core_rst_n` disagrees, which is at most one wait length after the request. A wrong oscillator-state decision turns a 16-cycle pulse into a full wait, or the reverse, and shows 17 cycles after the request. A synchronizer with the wrong depth shifts the first low cycle of an external reset by one edge. A bad cause register shows on the cycle after the event and stays visible until the next event.

// File: rtl/rsc_pkg.sv
// Shared encodings for the reset source sequencing controller.
// Assumes a two-bit oscillator state from the clock controller.
package rsc_pkg;
    typedef enum logic [1:0] {
        OSC_RUN  = 2'b00,
        OSC_STOP = 2'b01,
        OSC_WARM = 2'b10,
        OSC_RSVD = 2'b11
    } osc_state_e;

    localparam int CAUSE_W = 4;
    localparam int CI_POR  = 0;
    localparam int CI_EXT  = 1;
    localparam int CI_SW   = 2;
    localparam int CI_WDT  = 3;
endpackage

// File: rtl/rsc_sync.sv
// Brings an asynchronous active-low pin into the clock domain.
// Output level is active high; rise flags the first synchronized cycle.
// Assumes STAGES >= 2.
module rsc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic level,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              last_q;

    // Shift the inverted pin through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], ~pin_n};
    end

    // Remember the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain[STAGES-1];
    end

    assign level = chain[STAGES-1];
    assign rise  = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/rsc_timer.sv
// Reloadable down counter. busy is high for exactly TICKS cycles
// after the last load. A load always restarts at full length.
module rsc_timer #(
    parameter int unsigned TICKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic busy
);
    localparam int W = $clog2(TICKS + 1);

    logic [W-1:0] cnt;

    // Reload on request, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt <= '0;
        else if (load)      cnt <= W'(TICKS);
        else if (cnt != '0) cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/rsc_cause.sv
// Holds the source set of the latest reset event. Only the
// controller reset clears it; core resets leave it alone.
module rsc_cause
    import rsc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CAUSE_W-1:0] ev,
    output logic [CAUSE_W-1:0] cause
);
    // Overwrite with this edge's events when there are any.
    always_ff @(posedge clk) begin
        if (!rst_n)        cause <= '0;
        else if (ev != '0) cause <= ev;
    end
endmodule

// File: rtl/rst_seq_ctrl.sv
// Reset source sequencing controller.
// Picks the reset length from the source and the oscillator state,
// runs a stabilization timer and an instruction-cycle pulse timer,
// and holds the core in reset while any timer or held request is active.
// Assumes sw_req/wdt_req are one-cycle pulses and the options are static.
module rst_seq_ctrl
    import rsc_pkg::*;
#(
    parameter int unsigned STAB_TICKS  = 16384,
    parameter int unsigned INSTR_TICKS = 4,
    parameter int unsigned PULSE_INSTR = 4,
    parameter int          SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               por_req,
    input  logic               ext_rst_n,
    input  logic               sw_req,
    input  logic               wdt_req,
    input  logic [1:0]         osc_state,
    input  logic               opt_por,
    input  logic               opt_rst_out,
    output logic               core_rst_n,
    output logic               pin_drive_low,
    output logic [CAUSE_W-1:0] cause
);
    localparam int unsigned PULSE_TICKS = INSTR_TICKS * PULSE_INSTR;

    logic               ext_level;
    logic               ext_rise;
    logic               por_q;
    logic               osc_live;
    logic               stab_load;
    logic               pulse_load;
    logic               stab_busy;
    logic               pulse_busy;
    logic [CAUSE_W-1:0] ev;

    rsc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_n (ext_rst_n),
        .level (ext_level),
        .rise  (ext_rise)
    );

    // Register the power-on request for hold and edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) por_q <= 1'b0;
        else        por_q <= por_req;
    end

    // Decide which timer each request starts.
    always_comb begin
        osc_live   = (osc_state == OSC_RUN);
        stab_load  = (opt_por & por_req)
                   | (opt_por & ext_rise & ~osc_live)
                   | ((sw_req | wdt_req) & ~osc_live);
        pulse_load = (sw_req | wdt_req) & osc_live;
    end

    rsc_timer #(.TICKS(STAB_TICKS)) u_stab (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (stab_load),
        .busy  (stab_busy)
    );

    rsc_timer #(.TICKS(PULSE_TICKS)) u_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (pulse_load),
        .busy  (pulse_busy)
    );

    // Collect the events of this edge for the cause register.
    always_comb begin
        ev         = '0;
        ev[CI_POR] = por_req & ~por_q;
        ev[CI_EXT] = ext_rise;
        ev[CI_SW]  = sw_req;
        ev[CI_WDT] = wdt_req;
    end

    rsc_cause u_cause (
        .clk   (clk),
        .rst_n (rst_n),
        .ev    (ev),
        .cause (cause)
    );

    // Core stays in reset while any timer or held request is active.
    assign core_rst_n    = ~(stab_busy | pulse_busy | ext_level | por_q);
    assign pin_drive_low = opt_rst_out & (stab_busy | pulse_busy);
endmodule

// File: rtl/rsc_chk.sv
// Temporal checks on the controller ports, attached by bind.
module rsc_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ext_rst_n,
    input logic       sw_req,
    input logic       wdt_req,
    input logic [1:0] osc_state,
    input logic       opt_rst_out,
    input logic       core_rst_n,
    input logic       pin_drive_low,
    input logic       cause_wdt
);
    // R8
    pin_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pin_drive_low |-> !core_rst_n);

    // R8
    pin_option_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !opt_rst_out |-> !pin_drive_low);

    // R2
    pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((sw_req || wdt_req) && osc_state == 2'b00) |=> !core_rst_n);

    // R3
    stab_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((sw_req || wdt_req) && osc_state != 2'b00 && opt_rst_out)
        |=> (!core_rst_n && pin_drive_low));

    // R4
    ext_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && !$past(ext_rst_n, 2)) |-> !core_rst_n);

    // R9
    cause_wdt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_req |=> cause_wdt);
endmodule

bind rst_seq_ctrl rsc_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ext_rst_n     (ext_rst_n),
    .sw_req        (sw_req),
    .wdt_req       (wdt_req),
    .osc_state     (osc_state),
    .opt_rst_out   (opt_rst_out),
    .core_rst_n    (core_rst_n),
    .pin_drive_low (pin_drive_low),
    .cause_wdt     (cause[3])
);

// File: tb/rst_seq_ctrl_bench.sv
module rst_seq_ctrl_bench;
    localparam int STAB  = 40;
    localparam int PULSE = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       por_req = 1'b0;
    logic       ext_rst_n = 1'b1;
    logic       sw_req = 1'b0;
    logic       wdt_req = 1'b0;
    logic [1:0] osc_state = 2'b00;
    logic       opt_por = 1'b1;
    logic       opt_rst_out = 1'b1;
    logic       core_rst_n;
    logic       pin_drive_low;
    logic [3:0] cause;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    bit    live = 1'b0;
    string cur_req = "R1";

    // reference model state
    int       m_stab = 0, m_pulse = 0, m_e1 = 0, m_e2 = 0, m_ed = 0, m_porq = 0;
    logic [3:0] m_cause = 4'b0;

    always #5 clk = ~clk;

    rst_seq_ctrl #(.STAB_TICKS(STAB), .INSTR_TICKS(4), .PULSE_INSTR(4)) u_rst_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .por_req(por_req), .ext_rst_n(ext_rst_n),
        .sw_req(sw_req), .wdt_req(wdt_req), .osc_state(osc_state),
        .opt_por(opt_por), .opt_rst_out(opt_rst_out),
        .core_rst_n(core_rst_n), .pin_drive_low(pin_drive_low), .cause(cause)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_stab = 0; m_pulse = 0; m_e1 = 0; m_e2 = 0; m_ed = 0; m_porq = 0;
            m_cause = 4'b0;
        end else begin
            int rise, nstab, npulse;
            logic [3:0] evs;
            rise   = (m_e2 == 1 && m_ed == 0) ? 1 : 0;
            nstab  = (m_stab > 0) ? m_stab - 1 : 0;
            npulse = (m_pulse > 0) ? m_pulse - 1 : 0;
            if (opt_por && por_req) nstab = STAB;
            if (opt_por && rise == 1 && osc_state != 2'b00) nstab = STAB;
            if ((sw_req || wdt_req) && osc_state != 2'b00) nstab = STAB;
            if ((sw_req || wdt_req) && osc_state == 2'b00) npulse = PULSE;
            evs = {wdt_req, sw_req, rise == 1, por_req && m_porq == 0};
            if (evs != 4'b0) m_cause = evs;
            m_stab = nstab; m_pulse = npulse;
            m_ed = m_e2; m_e2 = m_e1; m_e1 = ext_rst_n ? 0 : 1; m_porq = por_req ? 1 : 0;
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (live) begin
            int busy;
            busy = (m_stab > 0 || m_pulse > 0) ? 1 : 0;
            check({cur_req, " core_rst_n"}, int'(core_rst_n),
                  (busy == 1 || m_e2 == 1 || m_porq == 1) ? 0 : 1);
            check({cur_req, " pin R8"}, int'(pin_drive_low), (opt_rst_out && busy == 1) ? 1 : 0);
            check({cur_req, " cause R9"}, int'(cause), int'(m_cause));
        end
    end

    task automatic count_low(output int nc, output int np);
        int guard = 0;
        nc = 0; np = 0;
        while (core_rst_n && guard < 8) begin @(negedge clk); guard++; end
        while (!core_rst_n) begin
            nc++;
            if (pin_drive_low) np++;
            @(negedge clk);
        end
    endtask

    // kind: 0 sw, 1 wdt, 2 ext, 3 por, 4 sw+wdt, 5 sw twice
    task automatic drive(input int kind, input int hold);
        case (kind)
            0: sw_req = 1'b1;
            1: wdt_req = 1'b1;
            2: ext_rst_n = 1'b0;
            3: por_req = 1'b1;
            default: begin sw_req = 1'b1; if (kind == 4) wdt_req = 1'b1; end
        endcase
        repeat (hold) @(negedge clk);
        sw_req = 1'b0; wdt_req = 1'b0; ext_rst_n = 1'b1; por_req = 1'b0;
        if (kind == 5) begin
            repeat (9) @(negedge clk);
            sw_req = 1'b1;
            @(negedge clk);
            sw_req = 1'b0;
        end
    endtask

    task automatic scen(input string tag, input int kind, input int hold,
                        input int exp_core, input int exp_pin, input int exp_cause);
        int nc, np;
        cur_req = tag;
        fork
            drive(kind, hold);
            count_low(nc, np);
        join
        check({tag, " low cycles"}, nc, exp_core);
        check({tag, " pin cycles R8"}, np, exp_pin);
        repeat (4) @(negedge clk);
        check({tag, " cause kept R9"}, int'(cause), exp_cause);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        live = 1'b1;
        // R1 reset state
        check("R1 core_rst_n", int'(core_rst_n), 1);
        check("R1 pin", int'(pin_drive_low), 0);
        check("R1 cause", int'(cause), 0);
        repeat (3) @(negedge clk);

        // R2 software pulse in main clock mode
        scen("R2 sw run", 0, 1, PULSE, PULSE, 4'b0100);
        // R3 watchdog while oscillator stopped
        osc_state = 2'b01;
        scen("R3 wdt stop", 1, 1, STAB, STAB, 4'b1000);
        // R3 software while warming, power-on option off
        osc_state = 2'b10; opt_por = 1'b0;
        scen("R3 sw warm", 0, 1, STAB, STAB, 4'b0100);
        opt_por = 1'b1; osc_state = 2'b00;
        // R4 external reset in main clock mode
        scen("R4 ext run", 2, 10, 10, 0, 4'b0010);
        // R5 external in stop mode, short and long pin hold
        osc_state = 2'b01;
        scen("R5 ext stop short", 2, 5, STAB + 1, STAB, 4'b0010);
        scen("R5 ext stop long", 2, 60, 60, STAB, 4'b0010);
        osc_state = 2'b00;
        // R6 power-on with option, held 3 cycles
        scen("R6 por opt", 3, 3, STAB + 2, STAB + 2, 4'b0001);
        // R7 without option: no wait for power-on or external
        opt_por = 1'b0;
        scen("R7 por noopt", 3, 3, 3, 0, 4'b0001);
        osc_state = 2'b01;
        scen("R7 ext stop noopt", 2, 5, 5, 0, 4'b0010);
        osc_state = 2'b00; opt_por = 1'b1;
        // R9 simultaneous sources
        scen("R9 sw+wdt", 4, 1, PULSE, PULSE, 4'b1100);
        // R10 second request restarts the pulse
        scen("R10 sw twice", 5, 1, PULSE + 10, PULSE + 10, 4'b0100);
        // R8 no pin drive when the option is off
        opt_rst_out = 1'b0;
        scen("R8 sw nopin", 0, 1, PULSE, 0, 4'b0100);
        osc_state = 2'b01;
        scen("R8 wdt stop nopin", 1, 1, STAB, 0, 4'b1000);
        osc_state = 2'b00; opt_rst_out = 1'b1;

        // R9 only the controller reset clears the cause
        live = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        live = 1'b1;
        check("R9 cleared by rst_n", int'(cause), 0);
        check("R1 core after rst_n", int'(core_rst_n), 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1 actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule